// File: doc/BRIEF.md
# Printer Port Host Register Block

This block sits on the host side of a printer-style parallel port. A byte-wide register bus with an address, a read strobe and a write strobe reaches three registers: a data byte, a status byte and a control byte. Software writes the byte to print into the data register and then pulses the strobe bit in the control register. The block then hands that byte to a printer-side sink over a valid/ready stream. It also keeps a small model of the printer handshake, which software sees in the status register through a series of reads.

After a strobe, the status register shows the port as busy. Each later status read advances the handshake by one step. The first read drops the acknowledge bit. The next read restores both acknowledge and not-busy, and if interrupts are enabled it raises an interrupt. The next status read clears that interrupt. When the direction bit is set, data register reads return a byte latched from the printer side.

Top module: `pp_host_regs`

## Requirements
- R1: After reset, a control read returns 0xCC, a status read returns 0xD9, a data read returns 0x00, `out_valid` is 0 and `irq` is 0.
- R2: Offset 0 is data, offset 1 is status and offset 2 is control. A data write stores the byte. A data read returns the stored byte when control bit 5 (direction) is 0, and returns `in_byte` when it is 1. Control reads return the written bits 5:0 with bits 7:6 forced to 1.
- R3: A control write with bit 2 (init, active low) at 0 loads status with 0xD8.
- R4: A control write with bit 2 = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1 clears status bit 7 (not-busy). If the stored strobe bit was 0 before that write, the data byte is emitted once on the output stream. A write that does not raise the strobe emits nothing.
- R5: An emitted byte holds `out_valid` high with `out_byte` stable until a cycle with `out_ready` high. A strobe rising edge while a byte is still held is dropped, and the held byte is kept.
- R6: A status read advances the handshake only when status bit 7 is 0, the stored strobe bit is 0 and no byte is held. If status bit 6 (acknowledge) is 1, the read clears it. Otherwise the read sets bits 7 and 6 again.
- R7: When control bit 4 (interrupt enable) is 1, the read that restores bits 7 and 6 sets `irq` high. The next status read clears it. When bit 4 is 0, `irq` stays low.
- R8: Writes to status and to offsets 3 to 7 are ignored. Reads at offsets 3 to 7 return 0xFF.
- R9: `bus_rdata` is registered. It shows the value that the register had before the read's side effects, in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| in_byte | input | 8 | Latched byte from the printer side |
| out_valid | output | 1 | Output byte pending |
| out_ready | input | 1 | Sink accepts the byte |
| out_byte | output | 8 | Byte toward the printer |
| irq | output | 1 | Interrupt, high while an acknowledge is pending |

## Verification
On every cycle, the assertions check stream stability while the sink stalls, the rule that a new output byte appears only after a control write that raises the strobe, the rule that the interrupt rises only after a status read, and the quiet state after reset. Some behaviours only the bench's scenarios can show: the exact status values at each step of the read-driven handshake, the switch of the data read between the stored byte and the input latch, a dropped strobe while a byte is held, and the ignored writes. The bench compares these against values it derives on its own.

// File: rtl/pp_regs_pkg.sv
package pp_regs_pkg;

    localparam int BYTE_W = 8;

    // register offsets
    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_CTRL = 2;

    typedef struct packed {
        logic       nbusy;
        logic       ack;
        logic       paper;
        logic       online;
        logic       nerror;
        logic [1:0] rsvd;
        logic       tmo;
    } status_t;

    typedef struct packed {
        logic dir;
        logic irq_en;
        logic sel;
        logic init_n;
        logic alf;
        logic stb;
    } ctrl_t;

    localparam logic [BYTE_W-1:0] STATUS_RST  = 8'hD9;
    localparam logic [BYTE_W-1:0] STATUS_INIT = 8'hD8;
    localparam logic [5:0]        CTRL_RST    = 6'h0C;
    localparam logic [BYTE_W-1:0] UNMAPPED_RD = 8'hFF;

    function automatic logic [BYTE_W-1:0] ctrl_readback(input ctrl_t c);
        return {2'b11, c};
    endfunction

    function automatic logic strobe_fires(input ctrl_t nxt);
        return nxt.init_n && nxt.sel && nxt.stb;
    endfunction

endpackage

// File: rtl/pp_ctrl_regs.sv
module pp_ctrl_regs
    import pp_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] data_q,
    output ctrl_t             ctrl_q,
    output logic              emit
);
    ctrl_t ctrl_nxt;

    always_comb begin
        ctrl_nxt = ctrl_t'(wdata[5:0]);
        emit     = ctrl_wr && strobe_fires(ctrl_nxt) && !ctrl_q.stb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            ctrl_q <= ctrl_t'(CTRL_RST);
        end else begin
            if (data_wr) data_q <= wdata;
            if (ctrl_wr) ctrl_q <= ctrl_nxt;
        end
    end
endmodule

// File: rtl/pp_status_hs.sv
module pp_status_hs
    import pp_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              stat_rd,
    input  ctrl_t             ctrl_q,
    input  logic              holding,
    output status_t           stat_q,
    output logic              pend_q
);
    ctrl_t ctrl_nxt;
    logic  advance;

    always_comb begin
        ctrl_nxt = ctrl_t'(wdata[5:0]);
        advance  = stat_rd && !stat_q.nbusy && !ctrl_q.stb && !holding;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= status_t'(STATUS_RST);
            pend_q <= 1'b0;
        end else begin
            if (stat_rd && pend_q) pend_q <= 1'b0;
            if (ctrl_wr) begin
                if (!ctrl_nxt.init_n)
                    stat_q <= status_t'(STATUS_INIT);
                else if (strobe_fires(ctrl_nxt))
                    stat_q.nbusy <= 1'b0;
            end else if (advance) begin
                if (stat_q.ack) begin
                    stat_q.ack <= 1'b0;
                end else begin
                    stat_q.ack   <= 1'b1;
                    stat_q.nbusy <= 1'b1;
                    if (ctrl_q.irq_en) pend_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pp_out_hold.sv
module pp_out_hold
    import pp_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              emit,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              ready,
    output logic              valid,
    output logic [BYTE_W-1:0] byte_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            byte_out <= '0;
        end else if (valid) begin
            if (ready) valid <= 1'b0;
        end else if (emit) begin
            valid    <= 1'b1;
            byte_out <= byte_in;
        end
    end
endmodule

// File: rtl/pp_host_regs.sv
module pp_host_regs
    import pp_regs_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    logic              data_wr, ctrl_wr, stat_rd, emit, pend_q;
    logic [BYTE_W-1:0] data_q, rd_mux;
    ctrl_t             ctrl_q;
    status_t           stat_q;

    assign data_wr = bus_wr && (bus_addr == A_DATA);
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign stat_rd = bus_rd && (bus_addr == A_STAT);

    pp_ctrl_regs u_ctrl (
        .clk(clk), .rst(rst), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
        .wdata(bus_wdata), .data_q(data_q), .ctrl_q(ctrl_q), .emit(emit)
    );

    pp_status_hs u_stat (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
        .stat_rd(stat_rd), .ctrl_q(ctrl_q), .holding(out_valid),
        .stat_q(stat_q), .pend_q(pend_q)
    );

    pp_out_hold u_out (
        .clk(clk), .rst(rst), .emit(emit), .byte_in(data_q),
        .ready(out_ready), .valid(out_valid), .byte_out(out_byte)
    );

    always_comb begin
        unique case (bus_addr)
            A_DATA:  rd_mux = ctrl_q.dir ? in_byte : data_q;
            A_STAT:  rd_mux = stat_q;
            A_CTRL:  rd_mux = ctrl_readback(ctrl_q);
            default: rd_mux = UNMAPPED_RD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = pend_q;
endmodule

// File: rtl/pp_host_regs_chk.sv
module pp_host_regs_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_byte,
    input logic              irq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !irq));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R4
    emit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(bus_wr && bus_addr == ADDR_W'(2) && bus_wdata[0]));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(bus_rd && bus_addr == ADDR_W'(1)));
endmodule

bind pp_host_regs pp_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .irq(irq)
);

// File: tb/pp_host_regs_tb.sv
module pp_host_regs_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0, out_ready = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, out_byte;
    logic [7:0] in_byte = 8'hA5;
    logic       out_valid, irq;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    pp_host_regs u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte), .irq(irq)
    );

    // {kind[1:0], addr[2:0], data[7:0], expect[7:0], irq_after, valid_after}
    // kind 0 = write, 1 = read and compare, 2 = one-cycle sink accept (expect = out_byte)
    localparam int NV = 39;
    localparam logic [22:0] VEC [NV] = '{
        {2'd1,3'd2,8'h00,8'hCC,1'b0,1'b0},  // R1 control reset
        {2'd1,3'd1,8'h00,8'hD9,1'b0,1'b0},  // R1 status reset
        {2'd1,3'd0,8'h00,8'h00,1'b0,1'b0},  // R1 data reset
        {2'd0,3'd0,8'h5A,8'h00,1'b0,1'b0},
        {2'd1,3'd0,8'h00,8'h5A,1'b0,1'b0},  // R2
        {2'd0,3'd2,8'h1C,8'h00,1'b0,1'b0},
        {2'd0,3'd2,8'h1D,8'h00,1'b0,1'b1},  // R4 emit
        {2'd1,3'd1,8'h00,8'h59,1'b0,1'b1},  // R6 no advance, strobe high
        {2'd0,3'd2,8'h1C,8'h00,1'b0,1'b1},
        {2'd1,3'd1,8'h00,8'h59,1'b0,1'b1},  // R6 no advance, byte held
        {2'd2,3'd0,8'h00,8'h5A,1'b0,1'b0},  // R5 accept
        {2'd1,3'd1,8'h00,8'h59,1'b0,1'b0},  // R6 ack drop
        {2'd1,3'd1,8'h00,8'h19,1'b1,1'b0},  // R6 R7 restore, irq
        {2'd1,3'd1,8'h00,8'hD9,1'b0,1'b0},  // R7 clear
        {2'd1,3'd1,8'h00,8'hD9,1'b0,1'b0},  // R6 idle
        {2'd0,3'd1,8'h00,8'h00,1'b0,1'b0},
        {2'd1,3'd1,8'h00,8'hD9,1'b0,1'b0},  // R8 status write ignored
        {2'd0,3'd2,8'h3C,8'h00,1'b0,1'b0},
        {2'd1,3'd2,8'h00,8'hFC,1'b0,1'b0},  // R2 readback
        {2'd1,3'd0,8'h00,8'hA5,1'b0,1'b0},  // R2 input latch
        {2'd0,3'd0,8'h77,8'h00,1'b0,1'b0},
        {2'd1,3'd0,8'h00,8'hA5,1'b0,1'b0},  // R2
        {2'd0,3'd2,8'h1C,8'h00,1'b0,1'b0},
        {2'd1,3'd0,8'h00,8'h77,1'b0,1'b0},  // R2
        {2'd0,3'd2,8'h18,8'h00,1'b0,1'b0},
        {2'd1,3'd1,8'h00,8'hD8,1'b0,1'b0},  // R3
        {2'd1,3'd5,8'h00,8'hFF,1'b0,1'b0},  // R8
        {2'd0,3'd5,8'h00,8'h00,1'b0,1'b0},
        {2'd1,3'd2,8'h00,8'hD8,1'b0,1'b0},  // R8 control untouched
        {2'd0,3'd2,8'h0C,8'h00,1'b0,1'b0},
        {2'd0,3'd0,8'h33,8'h00,1'b0,1'b0},
        {2'd0,3'd2,8'h0D,8'h00,1'b0,1'b1},  // R4
        {2'd0,3'd2,8'h0D,8'h00,1'b0,1'b1},
        {2'd2,3'd0,8'h00,8'h33,1'b0,1'b0},  // R5
        {2'd0,3'd2,8'h0D,8'h00,1'b0,1'b0},  // R4 no rising strobe
        {2'd0,3'd2,8'h0C,8'h00,1'b0,1'b0},
        {2'd1,3'd1,8'h00,8'h58,1'b0,1'b0},  // R6
        {2'd1,3'd1,8'h00,8'h18,1'b0,1'b0},  // R7 no irq when disabled
        {2'd1,3'd1,8'h00,8'hD8,1'b0,1'b0}   // R6
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // R9: rdata sampled the cycle after the strobe
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic accept();
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 out_valid", {7'd0, out_valid}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            case (v[22:21])
                2'd0: wr(v[20:18], v[17:10]);
                2'd1: begin
                    rd(v[20:18], r);
                    check("R9 vector read", r, v[9:2]);
                end
                default: begin
                    check("R5 out_byte", out_byte, v[9:2]);
                    accept();
                end
            endcase
            check("R7 irq", {7'd0, irq}, {7'd0, v[1]});
            check("R5 out_valid", {7'd0, out_valid}, {7'd0, v[0]});
        end

        // R5: strobe while a byte is held is dropped
        wr(3'd0, 8'h11);
        wr(3'd2, 8'h0C);
        wr(3'd2, 8'h0D);
        wr(3'd0, 8'h22);
        wr(3'd2, 8'h0C);
        wr(3'd2, 8'h0D);
        check("R5 held byte kept", out_byte, 8'h11);
        check("R5 valid held", {7'd0, out_valid}, 8'd1);
        accept();
        check("R5 dropped byte not sent", {7'd0, out_valid}, 8'd0);

        // R1: reset in the middle of traffic
        wr(3'd2, 8'h0C);
        wr(3'd2, 8'h0D);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 valid after reset", {7'd0, out_valid}, 8'd0);
        rd(3'd2, r); check("R1 control after reset", r, 8'hCC);
        rd(3'd1, r); check("R1 status after reset", r, 8'hD9);
        rd(3'd0, r); check("R1 data after reset", r, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule